// File: doc/BRIEF.md
# Byte-Lane Error-Correcting Word Memory

This block is a synchronous word memory of 16-bit entries in which each byte lane carries its own error-correcting code. On a write, every enabled lane turns its 8 data bits into a 13-bit codeword: an extended Hamming code with four position checks plus one overall parity bit. The codeword goes into that lane's own array. On a read, each lane's codeword is decoded on its own. A single flipped bit is repaired and a double flip is detected. The lane results are then folded into two shared status outputs.

The two status outputs give four cases. With both low the word is clean. The corrected flag alone means at least one lane was repaired and the word is good. The uncorrectable flag alone means at least one lane holds a double fault and the word must not be trusted. Both high means one lane was repaired while the other was lost. Status and data are registered and appear one cycle after the read request, only when output is enabled. A test-only XOR mask, applied on the way into the arrays, lets a bench plant faults of any weight in any stored bit.

Top module: `bytewise_secded_mem`

## Requirements
- R1: After reset, `rd_vld`, `corr_flag` and `uncorr_flag` are low, and every location reads back as zero with both flags low.
- R2: A read (`req_en`=1, `wr_en`=0, `rd_oe`=1) raises `rd_vld` in the next cycle, with `rd_data` holding the last value written to that address and both flags low when no fault was injected.
- R3: On a write, `byte_en[0]` selects bits 7:0 and `byte_en[1]` selects bits 15:8. A lane whose enable is low keeps its stored content, including its check bits.
- R4: A fault in any one of a lane's 13 stored bits is repaired. The read returns the written data with `corr_flag`=1 and `uncorr_flag`=0.
- R5: Any two faulty bits within one lane, with the other lane clean, give `uncorr_flag`=1 and `corr_flag`=0.
- R6: A single fault in one lane together with a double fault in the other gives both flags high, and the repaired lane's byte is correct.
- R7: During a read, a lane whose `byte_en` bit is low returns zero in its byte of `rd_data` and adds nothing to either flag.
- R8: `rd_vld` and both flags stay low in the cycle after a write, after a read with `rd_oe`=0, and after an idle cycle.
- R9: On a write, `inj_mask` bits [13L+12:13L] are XORed into the stored codeword of lane L. Mask bits of a lane that is not being written have no effect.
- R10: The flags follow the address being read. A clean location read right after a faulty one reports both flags low, and two back-to-back reads of one address give identical data and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; clears the arrays and the outputs |
| req_en | input | 1 | Access request for this cycle |
| wr_en | input | 1 | 1 = write access, 0 = read access |
| rd_oe | input | 1 | Output enable for reads |
| addr | input | ADDR_W (4) | Word address |
| byte_en | input | LANES (2) | Per-lane enable for both reads and writes |
| wdata | input | 16 | Write data |
| inj_mask | input | 26 | Test fault mask, 13 bits per lane, XORed into stored codewords |
| rd_vld | output | 1 | Read data and flags are valid |
| rd_data | output | 16 | Corrected read data; disabled lanes read zero |
| corr_flag | output | 1 | At least one enabled lane had a repaired single fault |
| uncorr_flag | output | 1 | At least one enabled lane had an uncorrectable double fault |

## Verification
Every single-bit position of every lane is faulted in turn, which separates correct repair of data bits, check bits and the overall parity bit from a miscomputed syndrome. All 78 two-bit pairs per lane are then applied. Any pair classified as a single fault, or repaired into the wrong bit, shows up as a wrong flag combination. Mixed single-and-double faults across the two lanes confirm the flag merge. Partial writes, reads with a lane disabled, a mask on a lane that is not written, and output-disabled reads separate lane isolation from the decode logic.

// File: rtl/bsm_pkg.sv
// Shared constants, types and codeword functions for the byte-lane memory.
// Codeword layout: bit 0 is overall parity; bits HAM_LEN..1 are Hamming
// positions 1..HAM_LEN, with checks at powers of two and data elsewhere.
package bsm_pkg;
    localparam int LANE_W  = 8;
    localparam int HAM_PAR = 4;
    localparam int HAM_LEN = LANE_W + HAM_PAR;
    localparam int CODE_W  = HAM_LEN + 1;
    localparam int SYN_W   = HAM_PAR;
    localparam int IDX_W   = $clog2(CODE_W);
    localparam int DIDX_W  = $clog2(LANE_W);

    typedef logic [CODE_W-1:0] lane_code_t;
    typedef logic [LANE_W-1:0] lane_data_t;

    // Build one lane codeword from a data byte.
    function automatic lane_code_t code_pack(lane_data_t d);
        lane_code_t cw;
        logic [DIDX_W-1:0] k;
        logic b;
        cw = '0;
        k  = '0;
        for (int pos = 1; pos <= HAM_LEN; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                cw[IDX_W'(pos)] = d[k];
                k = k + 1'b1;
            end
        end
        for (int p = 0; p < HAM_PAR; p++) begin
            b = 1'b0;
            for (int pos = 1; pos <= HAM_LEN; pos++) begin
                if (((pos >> p) & 1) == 1) b = b ^ cw[IDX_W'(pos)];
            end
            cw[IDX_W'(1 << p)] = b;
        end
        cw[0] = ^cw[HAM_LEN:1];
        return cw;
    endfunction

    // Pull the data byte back out of a codeword.
    function automatic lane_data_t code_data(lane_code_t cw);
        lane_data_t d;
        logic [DIDX_W-1:0] k;
        d = '0;
        k = '0;
        for (int pos = 1; pos <= HAM_LEN; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                d[k] = cw[IDX_W'(pos)];
                k = k + 1'b1;
            end
        end
        return d;
    endfunction
endpackage

// File: rtl/bsm_lane_enc.sv
// Lane encoder: combinational data byte to 13-bit codeword.
// Assumes the codeword layout defined in bsm_pkg.
module bsm_lane_enc
    import bsm_pkg::*;
(
    input  lane_data_t data_i,
    output lane_code_t code_o
);
    // Encode the byte.
    assign code_o = code_pack(data_i);
endmodule

// File: rtl/bsm_lane_dec.sv
// Lane decoder: computes syndrome and overall parity, repairs a single
// fault and classifies the result. Purely combinational.
// Assumes a syndrome beyond HAM_LEN with bad parity is a multi-bit fault.
module bsm_lane_dec
    import bsm_pkg::*;
(
    input  lane_code_t code_i,
    output lane_data_t data_o,
    output logic       corr_o,
    output logic       dbl_o
);
    logic [SYN_W-1:0] syn;
    logic             par_bad;
    logic             syn_ok;
    lane_code_t       fixed;

    // Syndrome: XOR of the positions of all set bits.
    always_comb begin
        syn = '0;
        for (int pos = 1; pos <= HAM_LEN; pos++) begin
            if (code_i[IDX_W'(pos)]) syn = syn ^ SYN_W'(pos);
        end
    end

    assign par_bad = ^code_i;
    assign syn_ok  = (syn <= SYN_W'(HAM_LEN));

    // Flip the bit the syndrome points at when the fault is correctable.
    always_comb begin
        fixed = code_i;
        if (par_bad && syn_ok && (syn != '0)) begin
            fixed[IDX_W'(syn)] = ~code_i[IDX_W'(syn)];
        end
    end

    assign corr_o = par_bad && syn_ok;
    assign dbl_o  = (!par_bad && (syn != '0)) || (par_bad && !syn_ok);
    assign data_o = code_data(fixed);
endmodule

// File: rtl/bsm_lane_store.sv
// Lane storage: one codeword per address, cleared by reset to the all-zero
// codeword (the valid encoding of zero). Asynchronous read of the entry.
module bsm_lane_store
    import bsm_pkg::*;
#(
    parameter int ADDR_W = 4,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  lane_code_t        code_i,
    output lane_code_t        code_o
);
    lane_code_t mem [DEPTH];

    // Clear on reset, otherwise store the codeword on a lane write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_i) begin
            mem[addr_i] <= code_i;
        end
    end

    assign code_o = mem[addr_i];
endmodule

// File: rtl/bsm_flag_merge.sv
// Flag merge: folds per-lane repair and loss indications of the enabled
// lanes into the two shared status bits.
module bsm_flag_merge #(
    parameter int LANES = 2
) (
    input  logic [LANES-1:0] lane_on,
    input  logic [LANES-1:0] lane_corr,
    input  logic [LANES-1:0] lane_dbl,
    output logic             any_corr,
    output logic             any_dbl
);
    // OR-reduce over enabled lanes.
    assign any_corr = |(lane_corr & lane_on);
    assign any_dbl  = |(lane_dbl & lane_on);
endmodule

// File: rtl/bytewise_secded_mem.sv
// Top: word memory with an independent SEC-DED code per byte lane.
// One request per cycle; read results are registered (1-cycle latency).
// Assumes inj_mask is held at zero outside fault-injection tests.
module bytewise_secded_mem
    import bsm_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 2,
    localparam int DATA_W = LANES * LANE_W,
    localparam int MASK_W = LANES * CODE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_en,
    input  logic              wr_en,
    input  logic              rd_oe,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANES-1:0]  byte_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [MASK_W-1:0] inj_mask,
    output logic              rd_vld,
    output logic [DATA_W-1:0] rd_data,
    output logic              corr_flag,
    output logic              uncorr_flag
);
    logic              rd_fire;
    logic              wr_fire;
    logic [LANES-1:0]  lane_corr;
    logic [LANES-1:0]  lane_dbl;
    logic [DATA_W-1:0] lane_rdata;
    logic              any_corr;
    logic              any_dbl;

    assign rd_fire = req_en && !wr_en && rd_oe;
    assign wr_fire = req_en && wr_en;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        lane_code_t enc_code;
        lane_code_t wr_code;
        lane_code_t rd_code;
        lane_data_t dec_data;

        bsm_lane_enc u_enc (
            .data_i (wdata[l*LANE_W +: LANE_W]),
            .code_o (enc_code)
        );

        assign wr_code = enc_code ^ inj_mask[l*CODE_W +: CODE_W];

        bsm_lane_store #(.ADDR_W(ADDR_W)) u_store (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_i   (wr_fire && byte_en[l]),
            .addr_i (addr),
            .code_i (wr_code),
            .code_o (rd_code)
        );

        bsm_lane_dec u_dec (
            .code_i (rd_code),
            .data_o (dec_data),
            .corr_o (lane_corr[l]),
            .dbl_o  (lane_dbl[l])
        );

        assign lane_rdata[l*LANE_W +: LANE_W] = byte_en[l] ? dec_data : '0;
    end

    bsm_flag_merge #(.LANES(LANES)) u_merge (
        .lane_on   (byte_en),
        .lane_corr (lane_corr),
        .lane_dbl  (lane_dbl),
        .any_corr  (any_corr),
        .any_dbl   (any_dbl)
    );

    // Register read results; outputs are zero when no enabled read occurred.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_vld      <= 1'b0;
            rd_data     <= '0;
            corr_flag   <= 1'b0;
            uncorr_flag <= 1'b0;
        end else begin
            rd_vld      <= rd_fire;
            rd_data     <= rd_fire ? lane_rdata : '0;
            corr_flag   <= rd_fire && any_corr;
            uncorr_flag <= rd_fire && any_dbl;
        end
    end
endmodule

// File: rtl/bytewise_secded_mem_chk.sv
// Checker for bytewise_secded_mem: port-level timing and masking properties.
module bytewise_secded_mem_chk #(
    parameter int ADDR_W = 4,
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_en,
    input logic                     wr_en,
    input logic                     rd_oe,
    input logic [ADDR_W-1:0]        addr,
    input logic [LANES-1:0]         byte_en,
    input logic                     rd_vld,
    input logic [LANES*LANE_W-1:0]  rd_data,
    input logic                     corr_flag,
    input logic                     uncorr_flag
);
    logic rd_req;
    assign rd_req = req_en && !wr_en && rd_oe;

    // R8: flags only when a read result is presented.
    a_r8_flags_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_vld |-> (!corr_flag && !uncorr_flag));

    // R2: an enabled read is answered in the next cycle.
    a_r2_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_vld);

    // R8: no valid without a preceding enabled read.
    a_r8_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_vld);

    // R10: repeated read of one address gives the same answer.
    a_r10_repeat_read_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && $past(rd_req) && $stable(addr) && $stable(byte_en))
        |=> ($stable(rd_data) && $stable(corr_flag) && $stable(uncorr_flag)));

    // R7: a disabled lane reads as zero.
    for (genvar l = 0; l < LANES; l++) begin : g_mask
        a_r7_lane_off_zero: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_req && !byte_en[l]) |=> (rd_data[l*LANE_W +: LANE_W] == '0));
    end
endmodule

bind bytewise_secded_mem bytewise_secded_mem_chk #(
    .ADDR_W (ADDR_W),
    .LANES  (LANES),
    .LANE_W (bsm_pkg::LANE_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_en      (req_en),
    .wr_en       (wr_en),
    .rd_oe       (rd_oe),
    .addr        (addr),
    .byte_en     (byte_en),
    .rd_vld      (rd_vld),
    .rd_data     (rd_data),
    .corr_flag   (corr_flag),
    .uncorr_flag (uncorr_flag)
);

// File: tb/bytewise_secded_mem_bench.sv
`timescale 1ns/1ps
// Bench: sweeps every single and double fault position per lane and the
// lane-enable corner cases; expected values come from the written data.
module bytewise_secded_mem_bench;
    localparam int AW = 4;
    localparam int NL = 2;
    localparam int CW = 13;
    localparam int DW = 16;
    localparam int MW = NL * CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_en = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_oe = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [NL-1:0] byte_en = '0;
    logic [DW-1:0] wdata = '0;
    logic [MW-1:0] inj_mask = '0;
    logic          rd_vld;
    logic [DW-1:0] rd_data;
    logic          corr_flag;
    logic          uncorr_flag;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic          c_vld;
    logic [DW-1:0] c_data;
    logic          c_corr;
    logic          c_unc;

    always #2.5 clk = ~clk;

    bytewise_secded_mem #(.ADDR_W(AW), .LANES(NL)) u_bytewise_secded_mem (
        .clk(clk), .rst_n(rst_n), .req_en(req_en), .wr_en(wr_en), .rd_oe(rd_oe),
        .addr(addr), .byte_en(byte_en), .wdata(wdata), .inj_mask(inj_mask),
        .rd_vld(rd_vld), .rd_data(rd_data), .corr_flag(corr_flag),
        .uncorr_flag(uncorr_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic [NL-1:0] be, input logic [MW-1:0] m);
        @(negedge clk);
        req_en = 1'b1; wr_en = 1'b1; rd_oe = 1'b1;
        addr = a; wdata = d; byte_en = be; inj_mask = m;
        @(negedge clk);
        c_vld = rd_vld; c_corr = corr_flag; c_unc = uncorr_flag;
        req_en = 1'b0; wr_en = 1'b0; inj_mask = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, input logic [NL-1:0] be, input logic oe);
        @(negedge clk);
        req_en = 1'b1; wr_en = 1'b0; rd_oe = oe; addr = a; byte_en = be;
        @(negedge clk);
        c_vld = rd_vld; c_data = rd_data; c_corr = corr_flag; c_unc = uncorr_flag;
        req_en = 1'b0;
    endtask

    function automatic logic [DW-1:0] pat(input int a, input int b);
        return DW'(16'h5A3C ^ (a * 16'h0B17) ^ (b * 16'h2961));
    endfunction

    task automatic summary;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        logic [MW-1:0] m;
        logic [DW-1:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        chk("R1 rd_vld after reset", 32'(rd_vld), 0);
        chk("R1 flags after reset", {30'd0, corr_flag, uncorr_flag}, 0);
        for (int a = 0; a < 16; a++) begin
            rd(AW'(a), 2'b11, 1'b1);
            chk("R1 cleared word", 32'(c_data), 0);
            chk("R1 cleared flags", {30'd0, c_corr, c_unc}, 0);
        end

        // R2: clean write/read at every address.
        for (int a = 0; a < 16; a++) wr(AW'(a), pat(a, 1), 2'b11, '0);
        for (int a = 0; a < 16; a++) begin
            rd(AW'(a), 2'b11, 1'b1);
            chk("R2 rd_vld", 32'(c_vld), 1);
            chk("R2 data", 32'(c_data), 32'(pat(a, 1)));
            chk("R2 flags", {30'd0, c_corr, c_unc}, 0);
        end

        // R3: partial writes keep the other lane.
        wr(4'd3, 16'h1234, 2'b11, '0);
        wr(4'd3, 16'hABCD, 2'b01, '0);
        rd(4'd3, 2'b11, 1'b1);
        chk("R3 lower-only write", 32'(c_data), 32'h12CD);
        wr(4'd3, 16'h7788, 2'b10, '0);
        rd(4'd3, 2'b11, 1'b1);
        chk("R3 upper-only write", 32'(c_data), 32'h77CD);
        chk("R3 flags clean", {30'd0, c_corr, c_unc}, 0);

        // R4: every single-bit fault in every lane.
        for (int l = 0; l < NL; l++) begin
            for (int p = 0; p < CW; p++) begin
                d = pat(p, l + 7);
                m = '0; m[l*CW + p] = 1'b1;
                wr(AW'(p), d, 2'b11, m);
                rd(AW'(p), 2'b11, 1'b1);
                chk("R4 corrected data", 32'(c_data), 32'(d));
                chk("R4 flags {corr,unc}", {30'd0, c_corr, c_unc}, 2);
            end
        end

        // R5: every double-bit fault in every lane.
        for (int l = 0; l < NL; l++) begin
            for (int i = 0; i < CW; i++) begin
                for (int j = i + 1; j < CW; j++) begin
                    d = pat(i, j);
                    m = '0; m[l*CW + i] = 1'b1; m[l*CW + j] = 1'b1;
                    wr(AW'(i + j), d, 2'b11, m);
                    rd(AW'(i + j), 2'b11, 1'b1);
                    chk("R5 flags {corr,unc}", {30'd0, c_corr, c_unc}, 1);
                    chk("R5 clean lane data", 32'(l == 0 ? d[15:8] : d[7:0]),
                        32'(l == 0 ? c_data[15:8] : c_data[7:0]));
                end
            end
        end

        // R6: single in lower lane, double in upper lane.
        for (int p = 0; p < CW; p++) begin
            d = pat(p, 3);
            m = '0; m[p] = 1'b1;
            m[CW + p] = 1'b1; m[CW + ((p + 5) % CW)] = 1'b1;
            wr(AW'(p), d, 2'b11, m);
            rd(AW'(p), 2'b11, 1'b1);
            chk("R6 flags {corr,unc}", {30'd0, c_corr, c_unc}, 3);
            chk("R6 repaired lower byte", 32'(c_data[7:0]), 32'(d[7:0]));
        end

        // R7: read with a disabled lane holding a double fault.
        m = '0; m[CW + 2] = 1'b1; m[CW + 9] = 1'b1;
        wr(4'd9, 16'hC35A, 2'b11, m);
        rd(4'd9, 2'b01, 1'b1);
        chk("R7 upper lane zero", 32'(c_data), 32'h005A);
        chk("R7 disabled lane not flagged", {30'd0, c_corr, c_unc}, 0);
        rd(4'd9, 2'b10, 1'b1);
        chk("R7 enabled faulty lane flagged", {30'd0, c_corr, c_unc}, 1);
        chk("R7 lower lane zero", 32'(c_data[7:0]), 0);

        // R8: quiet outputs on write, oe low and idle.
        wr(4'd10, 16'h0F0F, 2'b11, '0);
        chk("R8 write cycle quiet", {29'd0, c_vld, c_corr, c_unc}, 0);
        rd(4'd9, 2'b11, 1'b0);
        chk("R8 oe low quiet", {29'd0, c_vld, c_corr, c_unc}, 0);
        chk("R8 oe low data", 32'(c_data), 0);
        @(negedge clk);
        chk("R8 idle quiet", {29'd0, rd_vld, corr_flag, uncorr_flag}, 0);

        // R9: mask bits of an unwritten lane have no effect.
        wr(4'd11, 16'h6611, 2'b11, '0);
        m = '0; m[CW + 0] = 1'b1; m[CW + 4] = 1'b1;
        wr(4'd11, 16'h6622, 2'b01, m);
        rd(4'd11, 2'b11, 1'b1);
        chk("R9 masked unwritten lane", 32'(c_data), 32'h6622);
        chk("R9 flags clean", {30'd0, c_corr, c_unc}, 0);

        // R10: flags follow the address.
        rd(4'd9, 2'b11, 1'b1);
        chk("R10 faulty location", {30'd0, c_corr, c_unc}, 1);
        rd(4'd10, 2'b11, 1'b1);
        chk("R10 next clean location", {30'd0, c_corr, c_unc}, 0);
        chk("R10 next clean data", 32'(c_data), 32'h0F0F);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule